// File: doc/BRIEF.md
# Edge-Latched Interrupt Router

This block gathers a wide set of edge-triggered interrupt inputs (256 by default) and turns them into a small grid of parent interrupt lines: a few lines for each of several cores. A rising edge on an input sets a sticky pending bit. Each input has its own enable bit and its own route byte. The route byte holds a bitmap of target cores and a node number, and the block only delivers inputs whose node number matches its own. Inputs are taken in groups of 32. Each group has a line-map byte that chooses which parent lines of the chosen cores the group drives.

Software controls the router through a simple 64-bit register bus with byte strobes. It reads the pending words and acknowledges by writing back the ones it has serviced. Before it rewrites a route byte it masks the input, and it unmasks the input afterwards. No parent line moves until the global enable bit is set.

Top module: `irq_router`

## Requirements
- R1: After reset every register reads zero and every parent line is low.
- R2: The pending bit of input n sets on a rising edge of `vec_i[n]` and stays set, even if the input stays high. It is bit n%64 of the status word at offset 0x1800 + 8*(n/64). An input that stays high does not set the bit again after it has been cleared.
- R3: Writing a status word clears each pending bit whose write-data bit is 1 and whose byte strobe is active. Bits written as 0 keep their value. A rising edge in the same cycle as a clear of the same bit wins, and the bit stays set.
- R4: The enable bit of input n is bit n%64 of the word at offset 0x1600 + 8*(n/64). A pending input whose enable bit is 0 drives no line, but its pending bit still latches. Setting the enable bit later delivers that pending input.
- R5: The route byte of input n is at byte offset 0x1c00 + n. Bits [3:0] select target cores 0..3, and any number of them may be set. Bits [7:4] give a node number. The input reaches cores only when that node number equals the parameter `LOCAL_NODE`.
- R6: The line-map byte of group g = n/32 is at byte offset 0x14c0 + g. Each set bit l makes the group drive parent line l. More than one bit may be set.
- R7: Output bit `core_irq_o[c*8 + l]` is the OR over every input that is pending, enabled, routed to core c and mapped to line l. It changes one clock after the state that drives it.
- R8: The global enable is bit 0 at offset 0x0000. While it is 0 every parent line is low, and pending state is kept.
- R9: A write changes only the bytes whose strobe bit is set. `bus_wstrb_i[k]` covers data bits [8k+7:8k].
- R10: A read at an 8-byte aligned address raises `bus_rvalid_o` for exactly one cycle, on the clock after the request, and returns the register value. Unmapped offsets, including 0x14a0 and 0x1680, read zero and ignore writes. Accesses with `bus_addr_i[2:0]` not zero are ignored and give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_i | input | NUM_VEC | Edge-triggered interrupt inputs |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 13 | Byte address of the access |
| bus_wdata_i | input | 64 | Write data |
| bus_wstrb_i | input | 8 | Byte write strobes |
| bus_rvalid_o | output | 1 | Read response valid |
| bus_rdata_o | output | 64 | Read response data |
| core_irq_o | output | 32 | Parent lines, bit c*8+l is line l of core c |

## Verification
The bench drives a rising edge into the same cycle as a write-one-to-clear of that same bit. A design that lets the clear win would lose the interrupt, and its lines would stay low. It holds an input high across a clear, and a level-sensitive latch would set the bit again and keep the line asserted. It also checks that masked and wrong-node inputs still latch but stay quiet, then deliver once they are unmasked or rerouted. It checks that a byte-strobed route write leaves the neighbouring route bytes unchanged. Finally it combines several cores and lines with two inputs pending at once, so that a missing OR or a swapped core and line index shows up as a wrong bit pattern.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ADDR_W       = 13;
    localparam int DW_W         = ADDR_W - 3;
    localparam int ROUTE_CORES  = 4;
    localparam int PARENT_LINES = 8;
    localparam int GRP_SIZE     = 32;

    localparam logic [ADDR_W-1:0] OFS_GLB   = 13'h0000;
    localparam logic [ADDR_W-1:0] OFS_LMAP  = 13'h14c0;
    localparam logic [ADDR_W-1:0] OFS_EN    = 13'h1600;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 13'h1800;
    localparam logic [ADDR_W-1:0] OFS_ROUTE = 13'h1c00;

    typedef struct packed {
        logic [3:0] node;
        logic [3:0] cores;
    } route_t;

    function automatic logic [63:0] strb_mask(input logic [7:0] s);
        logic [63:0] m;
        for (int k = 0; k < 8; k++) begin
            m[k*8 +: 8] = {8{s[k]}};
        end
        return m;
    endfunction

    function automatic logic [63:0] merge_bytes(input logic [63:0] old_v,
                                                input logic [63:0] new_v,
                                                input logic [63:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/irq_router_status.sv
module irq_router_status #(
    parameter int NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] vec_i,
    input  logic [NUM_VEC-1:0] clr_i,
    output logic [NUM_VEC-1:0] stat_o
);

    typedef struct packed {
        logic [NUM_VEC-1:0] prev;
        logic [NUM_VEC-1:0] stat;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_VEC-1:0] rise;

    always_comb begin
        rise       = vec_i & ~st_q.prev;
        st_d       = st_q;
        st_d.prev  = vec_i;
        // a new edge outranks an acknowledge of the same bit
        st_d.stat  = (st_q.stat & ~clr_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((stat_o & $past(rise)) == $past(rise)));

    assert_clear_wins_only_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~rise) != '0) |=> ((stat_o & $past(clr_i & ~rise)) == '0));

endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [63:0]            wdata_i,
    input  logic [7:0]             wstrb_i,
    input  logic [NUM_VEC-1:0]     stat_i,
    output logic                   glb_en_o,
    output logic [NUM_VEC-1:0]     en_o,
    output logic [((NUM_VEC/GRP_SIZE+7)/8)*64-1:0] lmap_o,
    output logic [NUM_VEC*8-1:0]   route_o,
    output logic [NUM_VEC-1:0]     clr_o,
    output logic                   rvalid_o,
    output logic [63:0]            rdata_o
);

    localparam int NUM_GRP   = NUM_VEC / GRP_SIZE;
    localparam int LMAP_DW   = (NUM_GRP + 7) / 8;
    localparam int LMAP_BITS = LMAP_DW * 64;
    localparam int WORD_DW   = NUM_VEC / 64;
    localparam int ROUTE_DW  = NUM_VEC / 8;
    localparam int GLB_DW0   = int'(OFS_GLB   >> 3);
    localparam int LMAP_DW0  = int'(OFS_LMAP  >> 3);
    localparam int EN_DW0    = int'(OFS_EN    >> 3);
    localparam int STAT_DW0  = int'(OFS_STAT  >> 3);
    localparam int ROUTE_DW0 = int'(OFS_ROUTE >> 3);

    typedef struct packed {
        logic                   glb;
        logic [LMAP_BITS-1:0]   lmap;
        logic [NUM_VEC-1:0]     en;
        logic [NUM_VEC*8-1:0]   route;
        logic                   rvalid;
        logic [63:0]            rdata;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [DW_W-1:0] dw;
    logic [63:0]     m;
    logic            wr_ok, rd_ok;

    always_comb begin
        dw    = addr_i[ADDR_W-1:3];
        m     = strb_mask(wstrb_i);
        wr_ok = req_i && we_i && (addr_i[2:0] == 3'b000);
        rd_ok = req_i && !we_i && (addr_i[2:0] == 3'b000);

        rg_d        = rg_q;
        rg_d.rvalid = rd_ok;
        rg_d.rdata  = '0;
        clr_o       = '0;

        if (wr_ok) begin
            if (int'(dw) == GLB_DW0 && wstrb_i[0]) begin
                rg_d.glb = wdata_i[0];
            end
            for (int i = 0; i < LMAP_DW; i++) begin
                if (int'(dw) == LMAP_DW0 + i) begin
                    rg_d.lmap[i*64 +: 64] = merge_bytes(rg_q.lmap[i*64 +: 64], wdata_i, m);
                end
            end
            for (int i = 0; i < WORD_DW; i++) begin
                if (int'(dw) == EN_DW0 + i) begin
                    rg_d.en[i*64 +: 64] = merge_bytes(rg_q.en[i*64 +: 64], wdata_i, m);
                end
                if (int'(dw) == STAT_DW0 + i) begin
                    clr_o[i*64 +: 64] = wdata_i & m;
                end
            end
            for (int i = 0; i < ROUTE_DW; i++) begin
                if (int'(dw) == ROUTE_DW0 + i) begin
                    rg_d.route[i*64 +: 64] = merge_bytes(rg_q.route[i*64 +: 64], wdata_i, m);
                end
            end
        end

        if (rd_ok) begin
            if (int'(dw) == GLB_DW0) begin
                rg_d.rdata = {63'd0, rg_q.glb};
            end
            for (int i = 0; i < LMAP_DW; i++) begin
                if (int'(dw) == LMAP_DW0 + i) rg_d.rdata = rg_q.lmap[i*64 +: 64];
            end
            for (int i = 0; i < WORD_DW; i++) begin
                if (int'(dw) == EN_DW0 + i)   rg_d.rdata = rg_q.en[i*64 +: 64];
                if (int'(dw) == STAT_DW0 + i) rg_d.rdata = stat_i[i*64 +: 64];
            end
            for (int i = 0; i < ROUTE_DW; i++) begin
                if (int'(dw) == ROUTE_DW0 + i) rg_d.rdata = rg_q.route[i*64 +: 64];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign glb_en_o = rg_q.glb;
    assign en_o     = rg_q.en;
    assign lmap_o   = rg_q.lmap;
    assign route_o  = rg_q.route;
    assign rvalid_o = rg_q.rvalid;
    assign rdata_o  = rg_q.rdata;

    assert_read_answers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && addr_i[2:0] == 3'b000) |=> rvalid_o);

    assert_no_stray_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !we_i && addr_i[2:0] == 3'b000) |=> !rvalid_o);

endmodule

// File: rtl/irq_router_fanout.sv
module irq_router_fanout
    import irq_router_pkg::*;
#(
    parameter int NUM_VEC    = 256,
    parameter int LOCAL_NODE = 0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                glb_en_i,
    input  logic [NUM_VEC-1:0]                  stat_i,
    input  logic [NUM_VEC-1:0]                  en_i,
    input  logic [NUM_VEC*8-1:0]                route_i,
    input  logic [(NUM_VEC/GRP_SIZE)*8-1:0]     lmap_i,
    output logic [ROUTE_CORES*PARENT_LINES-1:0] lines_o
);

    localparam int NUM_GRP = NUM_VEC / GRP_SIZE;
    localparam int OUT_W   = ROUTE_CORES * PARENT_LINES;

    typedef struct packed {
        logic [OUT_W-1:0] lines;
    } fo_t;

    fo_t fo_d, fo_q;
    logic [NUM_VEC-1:0]                      active;
    logic [NUM_GRP-1:0][ROUTE_CORES-1:0]     grp_hit;
    route_t                                  rt;

    always_comb begin
        active  = stat_i & en_i;
        grp_hit = '0;
        rt      = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            for (int k = 0; k < GRP_SIZE; k++) begin
                rt = route_t'(route_i[(g*GRP_SIZE + k)*8 +: 8]);
                for (int c = 0; c < ROUTE_CORES; c++) begin
                    if (active[g*GRP_SIZE + k] && rt.cores[c] && (rt.node == 4'(LOCAL_NODE))) begin
                        grp_hit[g][c] = 1'b1;
                    end
                end
            end
        end

        fo_d = '0;
        for (int c = 0; c < ROUTE_CORES; c++) begin
            for (int l = 0; l < PARENT_LINES; l++) begin
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (glb_en_i && grp_hit[g][c] && lmap_i[g*8 + l]) begin
                        fo_d.lines[c*PARENT_LINES + l] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fo_q <= '0;
        else        fo_q <= fo_d;
    end

    assign lines_o = fo_q.lines;

    assert_global_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> (lines_o == '0));

    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & en_i) == '0) |=> (lines_o == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_VEC    = 256,
    parameter int LOCAL_NODE = 0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_VEC-1:0]                  vec_i,
    input  logic                                bus_req_i,
    input  logic                                bus_we_i,
    input  logic [12:0]                         bus_addr_i,
    input  logic [63:0]                         bus_wdata_i,
    input  logic [7:0]                          bus_wstrb_i,
    output logic                                bus_rvalid_o,
    output logic [63:0]                         bus_rdata_o,
    output logic [ROUTE_CORES*PARENT_LINES-1:0] core_irq_o
);

    localparam int NUM_GRP   = NUM_VEC / GRP_SIZE;
    localparam int LMAP_BITS = ((NUM_GRP + 7) / 8) * 64;

    logic                   glb_en_w;
    logic [NUM_VEC-1:0]     en_w;
    logic [NUM_VEC-1:0]     stat_w;
    logic [NUM_VEC-1:0]     clr_w;
    logic [LMAP_BITS-1:0]   lmap_w;
    logic [NUM_VEC*8-1:0]   route_w;

    irq_router_regs #(.NUM_VEC(NUM_VEC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (bus_req_i),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .wstrb_i  (bus_wstrb_i),
        .stat_i   (stat_w),
        .glb_en_o (glb_en_w),
        .en_o     (en_w),
        .lmap_o   (lmap_w),
        .route_o  (route_w),
        .clr_o    (clr_w),
        .rvalid_o (bus_rvalid_o),
        .rdata_o  (bus_rdata_o)
    );

    irq_router_status #(.NUM_VEC(NUM_VEC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_i  (vec_i),
        .clr_i  (clr_w),
        .stat_o (stat_w)
    );

    irq_router_fanout #(.NUM_VEC(NUM_VEC), .LOCAL_NODE(LOCAL_NODE)) u_fanout (
        .clk      (clk),
        .rst_n    (rst_n),
        .glb_en_i (glb_en_w),
        .stat_i   (stat_w),
        .en_i     (en_w),
        .route_i  (route_w),
        .lmap_i   (lmap_w[NUM_GRP*8-1:0]),
        .lines_o  (core_irq_o)
    );

endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] vec = '0;
    logic         req = 1'b0;
    logic         we = 1'b0;
    logic [12:0]  addr = '0;
    logic [63:0]  wdata = '0;
    logic [7:0]   wstrb = '0;
    logic         rvalid;
    logic [63:0]  rdata;
    logic [31:0]  lines;

    int checks = 0;
    int fails  = 0;

    logic [31:0] oq_val[$];
    string       oq_tag[$];
    logic [63:0] rq_val[$];
    string       rq_tag[$];

    always #4 clk = ~clk;

    irq_router dut (
        .clk(clk), .rst_n(rst_n), .vec_i(vec),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_wstrb_i(wstrb),
        .bus_rvalid_o(rvalid), .bus_rdata_o(rdata), .core_irq_o(lines)
    );

    // monitor: compares queued expectations just after each rising edge
    initial begin
        logic [31:0] eo;
        logic [63:0] er;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (oq_val.size() > 0) begin
                eo = oq_val.pop_front();
                t  = oq_tag.pop_front();
                checks++;
                if (lines !== eo) begin
                    fails++;
                    $display("FAIL %s: lines %h expected %h", t, lines, eo);
                end
            end
            if (rvalid) begin
                checks++;
                if (rq_val.size() == 0) begin
                    fails++;
                    $display("FAIL R10: response with no read, data %h expected none", rdata);
                end else begin
                    er = rq_val.pop_front();
                    t  = rq_tag.pop_front();
                    if (rdata !== er) begin
                        fails++;
                        $display("FAIL %s: rdata %h expected %h", t, rdata, er);
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [12:0] a, input logic [63:0] d, input logic [7:0] s);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        req = 1'b0; we = 1'b0; wstrb = '0;
    endtask

    task automatic bus_read(input logic [12:0] a, input logic [63:0] e, input string t);
        @(negedge clk);
        rq_val.push_back(e); rq_tag.push_back(t);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic pulse(input int v);
        @(negedge clk);
        vec[v] = 1'b1;
        @(negedge clk);
        vec[v] = 1'b0;
    endtask

    task automatic expect_lines(input logic [31:0] e, input string t);
        oq_val.push_back(e); oq_tag.push_back(t);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: run still active, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_lines(32'h0, "R1 lines after reset");
        bus_read(13'h1800, 64'h0, "R1 status after reset");
        bus_read(13'h1600, 64'h0, "R1 enable after reset");

        // input 5 -> core 0, group 0 -> line 1
        bus_write(13'h1c00, 64'h01 << 40, 8'h20);
        bus_write(13'h14c0, 64'h02, 8'h01);
        bus_write(13'h1600, '1, 8'hff);
        pulse(5);
        expect_lines(32'h0, "R8 global enable off");
        bus_read(13'h1800, 64'h1 << 5, "R2 latched edge");
        bus_write(13'h0000, 64'h1, 8'h01);
        expect_lines(32'h2, "R8 R7 global enable on");
        bus_write(13'h1800, 64'h1 << 5, 8'hff);
        expect_lines(32'h0, "R3 clear");
        bus_read(13'h1800, 64'h0, "R3 status cleared");

        // held level is not an edge
        @(negedge clk);
        vec[5] = 1'b1;
        @(negedge clk);
        expect_lines(32'h2, "R2 rising edge delivered");
        bus_write(13'h1800, 64'h1 << 5, 8'hff);
        expect_lines(32'h0, "R2 held level no reset");
        expect_lines(32'h0, "R2 held level still quiet");
        vec[5] = 1'b0;

        // input 70: word1 bit6, group 2, core 1, line 3
        bus_write(13'h1c40, 64'h02 << 48, 8'h40);
        bus_write(13'h14c0, 64'h08 << 16, 8'h04);
        bus_write(13'h1608, '1, 8'hff);
        @(negedge clk);
        vec[70] = 1'b1;
        req = 1'b1; we = 1'b1; addr = 13'h1808; wdata = 64'h1 << 6; wstrb = 8'hff;
        @(negedge clk);
        req = 1'b0; we = 1'b0; wstrb = '0; vec[70] = 1'b0;
        expect_lines(32'h800, "R3 edge beats clear");
        bus_write(13'h1808, 64'h0, 8'hff);
        bus_read(13'h1808, 64'h1 << 6, "R3 zero write keeps bit");
        bus_write(13'h1808, 64'h1 << 6, 8'hff);
        expect_lines(32'h0, "R3 clear word1");

        // masking
        bus_write(13'h1608, ~(64'h1 << 6), 8'hff);
        pulse(70);
        expect_lines(32'h0, "R4 masked quiet");
        bus_read(13'h1808, 64'h1 << 6, "R4 masked still latches");
        bus_write(13'h1608, '1, 8'hff);
        expect_lines(32'h800, "R4 unmask delivers");

        // byte strobe on route word holding inputs 64..71
        bus_write(13'h1c40, 64'hffff_ffff_ffff_ff05, 8'h01);
        bus_read(13'h1c40, 64'h0002_0000_0000_0005, "R9 byte strobe");

        // node mismatch
        bus_write(13'h1c40, 64'h12 << 48, 8'h40);
        expect_lines(32'h0, "R5 foreign node");
        bus_write(13'h1c40, 64'h02 << 48, 8'h40);
        expect_lines(32'h800, "R5 local node again");
        bus_write(13'h1808, 64'h1 << 6, 8'hff);
        expect_lines(32'h0, "R3 clear again");

        // input 200: word3 bit8, group 6 -> lines 0 and 7, all cores
        bus_write(13'h1cc8, 64'h0f, 8'h01);
        bus_write(13'h14c0, 64'h81 << 48, 8'h40);
        bus_write(13'h1618, '1, 8'hff);
        pulse(200);
        expect_lines(32'h8181_8181, "R6 multi line multi core");
        pulse(5);
        expect_lines(32'h8181_8183, "R7 OR of two inputs");
        bus_write(13'h0000, 64'h0, 8'h01);
        expect_lines(32'h0, "R8 disable keeps pending");
        bus_write(13'h0000, 64'h1, 8'h01);
        expect_lines(32'h8181_8183, "R8 re-enable");

        // unmapped and misaligned
        bus_write(13'h1680, '1, 8'hff);
        bus_read(13'h1680, 64'h0, "R10 unmapped reads zero");
        bus_read(13'h14a0, 64'h0, "R10 node map offset zero");
        bus_write(13'h0004, 64'h0, 8'hff);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 13'h1804;
        @(negedge clk);
        req = 1'b0;
        expect_lines(32'h8181_8183, "R10 misaligned ignored");
        bus_read(13'h14c0, 64'h0081_0000_0008_0002, "R6 line map readback");
        bus_read(13'h0000, 64'h1, "R8 global readback");

        repeat (3) @(negedge clk);
        if (rq_val.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R10: %0d reads unanswered, expected 0", rq_val.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule